// File: doc/BRIEF.md
# Synthetic Traffic Destination Selector

This block picks the destination node for the next packet that a given source node injects into a network of 2^n nodes. A traffic generator presents its own node address, a pattern code and, for the hot-spot pattern, the address of the hot node, then pulses a request strobe. One clock later the block presents a registered destination address and a valid flag. When the flag is low, the generator skips that packet.

Four patterns are available. In uniform mode the destination is drawn at random from every node except the source. Bit reversal mirrors the bit order of the source address. Transpose exchanges the upper and lower halves of the source address. Hot spot sends every packet to one configured node.

Randomness comes from an internal Galois LFSR of maximal length. The LFSR is seeded with a nonzero constant and advances once per request. A uniform draw takes several address-wide slices of the LFSR state. It uses the first slice that differs from the source. If every slice equals the source, the destination is the source plus one, modulo N. This fallback biases the distribution by roughly N^-DRAWS only.

Top module: `traffic_dest_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dst_vld_o` is 0 and `dst_o` is 0.
- R2: A request sampled at a rising edge updates `dst_o` and `dst_vld_o` at that same edge. They are therefore visible one cycle after the strobe. Requests may be issued back to back, one per cycle.
- R3: In a cycle with no request, `dst_vld_o` is 0 after the next edge and `dst_o` keeps its previous value.
- R4: With `mode_i` = 2'b00 (uniform), the destination never equals the source and `dst_vld_o` is 1.
- R5: In uniform mode, with a fixed source and many requests, every other node is chosen. No node gets fewer than about a third of its fair share.
- R6: With `mode_i` = 2'b01 (bit reversal), destination bit i equals source bit n-1-i.
- R7: With `mode_i` = 2'b10 (transpose), the destination is the source with its lower n/2 bits moved to the upper half and its upper n/2 bits moved to the lower half. n must be even.
- R8: With `mode_i` = 2'b11 (hot spot), the destination equals `hot_i`.
- R9: When a permutation mode (bit reversal or transpose) maps the source onto itself, `dst_vld_o` is 0, and `dst_o` still shows the mapped address. In hot-spot mode, when the source is the hot node, `dst_vld_o` is 0. In every other case a request gives `dst_vld_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe for one destination |
| src_i | input | ADDR_W | Source node address |
| mode_i | input | 2 | Pattern: 00 uniform, 01 bit reversal, 10 transpose, 11 hot spot |
| hot_i | input | ADDR_W | Hot node address for mode 11 |
| dst_o | output | ADDR_W | Registered destination address |
| dst_vld_o | output | 1 | Destination is usable for a packet |

## Verification
A stuck or corrupted LFSR state would show up in uniform mode within a few dozen requests. Some nodes would never be chosen, or one node would be picked far more often than its share. A wrong slice selection or a wrong fallback would put the source itself on `dst_o` with the valid flag high, on the very request that triggers it. Errors in the permutation wiring or in the valid decision show up on the first request whose source exercises the affected bit, one cycle after the strobe. Errors in the hold logic appear on the first idle cycle after a request.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

    typedef enum logic [1:0] {
        MODE_UNIFORM   = 2'b00,
        MODE_BITREV    = 2'b01,
        MODE_TRANSPOSE = 2'b10,
        MODE_HOTSPOT   = 2'b11
    } dsel_mode_e;

endpackage

// File: rtl/dsel_lfsr.sv
module dsel_lfsr #(
    parameter int          LFSR_W = 32,
    parameter logic [31:0] TAPS   = 32'h8020_0003,
    parameter logic [31:0] SEED   = 32'hACE1_2468,
    parameter int          OUT_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [OUT_W-1:0] pool_o
);

    typedef struct packed {
        logic [LFSR_W-1:0] state;
    } lfsr_t;

    lfsr_t cur_q, nxt_d;

    generate
        if (OUT_W > LFSR_W) begin : g_bad_width
            $error("dsel_lfsr: pool wider than the LFSR");
        end
    endgenerate

    always_comb begin
        nxt_d = cur_q;
        if (step_i) begin
            if (cur_q.state[0]) begin
                nxt_d.state = (cur_q.state >> 1) ^ TAPS[LFSR_W-1:0];
            end else begin
                nxt_d.state = cur_q.state >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= SEED[LFSR_W-1:0];
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pool_o = cur_q.state[OUT_W-1:0];

endmodule

// File: rtl/dsel_perm.sv
module dsel_perm #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] src_i,
    output logic [ADDR_W-1:0] rev_o,
    output logic [ADDR_W-1:0] trn_o
);

    localparam int HALF = ADDR_W / 2;

    generate
        if (ADDR_W % 2 != 0) begin : g_odd
            $error("dsel_perm: transpose needs an even address width");
        end
        for (genvar b = 0; b < ADDR_W; b++) begin : g_rev
            assign rev_o[b] = src_i[ADDR_W-1-b];
        end
        for (genvar b = 0; b < HALF; b++) begin : g_trn
            assign trn_o[b + HALF] = src_i[b];
            assign trn_o[b]        = src_i[b + HALF];
        end
    endgenerate

endmodule

// File: rtl/dsel_uniform.sv
module dsel_uniform #(
    parameter int ADDR_W = 4,
    parameter int DRAWS  = 3,
    localparam int POOL_W = ADDR_W * DRAWS
) (
    input  logic [POOL_W-1:0] pool_i,
    input  logic [ADDR_W-1:0] src_i,
    output logic [ADDR_W-1:0] dst_o
);

    logic [ADDR_W-1:0] cand [DRAWS];
    logic [DRAWS-1:0]  hit;

    generate
        for (genvar g = 0; g < DRAWS; g++) begin : g_slice
            assign cand[g] = pool_i[g*ADDR_W +: ADDR_W];
            assign hit[g]  = (cand[g] != src_i);
        end
    endgenerate

    always_comb begin
        dst_o = src_i + ADDR_W'(1);
        for (int g = DRAWS - 1; g >= 0; g--) begin
            if (hit[g]) begin
                dst_o = cand[g];
            end
        end
    end

endmodule

// File: rtl/traffic_dest_sel.sv
module traffic_dest_sel
    import dsel_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DRAWS  = 3,
    parameter int LFSR_W = 32,
    parameter logic [31:0] TAPS = 32'h8020_0003,
    parameter logic [31:0] SEED = 32'hACE1_2468
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] hot_i,
    output logic [ADDR_W-1:0] dst_o,
    output logic              dst_vld_o
);

    localparam int POOL_W = ADDR_W * DRAWS;

    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic              vld;
    } out_t;

    out_t cur_q, nxt_d;

    logic [POOL_W-1:0] pool;
    logic [ADDR_W-1:0] uni_dst;
    logic [ADDR_W-1:0] rev_dst;
    logic [ADDR_W-1:0] trn_dst;
    dsel_mode_e        mode;

    assign mode = dsel_mode_e'(mode_i);

    dsel_lfsr #(
        .LFSR_W (LFSR_W),
        .TAPS   (TAPS),
        .SEED   (SEED),
        .OUT_W  (POOL_W)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (req_i),
        .pool_o (pool)
    );

    dsel_uniform #(
        .ADDR_W (ADDR_W),
        .DRAWS  (DRAWS)
    ) u_uni (
        .pool_i (pool),
        .src_i  (src_i),
        .dst_o  (uni_dst)
    );

    dsel_perm #(
        .ADDR_W (ADDR_W)
    ) u_perm (
        .src_i  (src_i),
        .rev_o  (rev_dst),
        .trn_o  (trn_dst)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        if (req_i) begin
            unique case (mode)
                MODE_UNIFORM: begin
                    nxt_d.dst = uni_dst;
                    nxt_d.vld = 1'b1;
                end
                MODE_BITREV: begin
                    nxt_d.dst = rev_dst;
                    nxt_d.vld = (rev_dst != src_i);
                end
                MODE_TRANSPOSE: begin
                    nxt_d.dst = trn_dst;
                    nxt_d.vld = (trn_dst != src_i);
                end
                MODE_HOTSPOT: begin
                    nxt_d.dst = hot_i;
                    nxt_d.vld = (hot_i != src_i);
                end
                default: begin
                    nxt_d.vld = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dst_o     = cur_q.dst;
    assign dst_vld_o = cur_q.vld;

endmodule

// File: rtl/dsel_checker.sv
module dsel_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [ADDR_W-1:0] src_i,
    input logic [1:0]        mode_i,
    input logic [ADDR_W-1:0] hot_i,
    input logic [ADDR_W-1:0] dst_o,
    input logic              dst_vld_o
);

    localparam int HALF = ADDR_W / 2;

    function automatic logic [ADDR_W-1:0] mirror(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        for (int i = 0; i < ADDR_W; i++) r[i] = a[ADDR_W-1-i];
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] halves(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        for (int i = 0; i < HALF; i++) begin
            r[i + HALF] = a[i];
            r[i]        = a[i + HALF];
        end
        return r;
    endfunction

    a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !dst_vld_o);

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(dst_o));

    a_r4_uniform_not_self: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b00) |=> (dst_vld_o && dst_o != $past(src_i)));

    a_r6_bitrev_map: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b01) |=> (dst_o == mirror($past(src_i))));

    a_r7_transpose_map: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b10) |=> (dst_o == halves($past(src_i))));

    a_r8_hot_target: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b11) |=> (dst_o == $past(hot_i)));

    a_r9_self_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i != 2'b00) |=> (dst_vld_o == (dst_o != $past(src_i))));

endmodule

bind traffic_dest_sel dsel_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .src_i     (src_i),
    .mode_i    (mode_i),
    .hot_i     (hot_i),
    .dst_o     (dst_o),
    .dst_vld_o (dst_vld_o)
);

// File: tb/traffic_dest_sel_tb.sv
module traffic_dest_sel_tb;

    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [AW-1:0] src_i = '0;
    logic [1:0]    mode_i = 2'b00;
    logic [AW-1:0] hot_i = '0;
    logic [AW-1:0] dst_o;
    logic          dst_vld_o;

    int n_chk = 0;
    int n_bad = 0;
    int hist [N];

    traffic_dest_sel #(.ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .src_i     (src_i),
        .mode_i    (mode_i),
        .hot_i     (hot_i),
        .dst_o     (dst_o),
        .dst_vld_o (dst_vld_o)
    );

    always #5 clk = ~clk;

    function automatic logic [AW-1:0] ref_rev(input logic [AW-1:0] a);
        logic [AW-1:0] r;
        for (int i = 0; i < AW; i++) r[i] = a[AW-1-i];
        return r;
    endfunction

    function automatic logic [AW-1:0] ref_trn(input logic [AW-1:0] a);
        return {a[AW/2-1:0], a[AW-1:AW/2]};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Drive one request, then sample the result on the next falling edge.
    task automatic one_req(input logic [AW-1:0] s, input logic [1:0] m, input logic [AW-1:0] h);
        @(negedge clk);
        src_i = s; mode_i = m; hot_i = h; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic check_perm(input logic [AW-1:0] s, input logic [1:0] m, input logic [AW-1:0] h);
        logic [AW-1:0] e;
        one_req(s, m, h);
        e = (m == 2'b01) ? ref_rev(s) : (m == 2'b10) ? ref_trn(s) : h;
        if (m == 2'b01) check(dst_o == e, "R6 bit reversal", dst_o, e);
        else if (m == 2'b10) check(dst_o == e, "R7 transpose", dst_o, e);
        else check(dst_o == e, "R8 hot spot", dst_o, e);
        check(dst_vld_o == (e != s), "R9 valid on self map", dst_vld_o, (e != s));
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [AW-1:0] last;
        void'($urandom(32'd1234));
        #2;
        check(dst_vld_o == 1'b0 && dst_o == '0, "R1 reset in progress", dst_vld_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dst_vld_o == 1'b0 && dst_o == '0, "R1 after reset", dst_o, 0);

        // R2/R3: one request, then idle cycles
        one_req(4'd3, 2'b01, '0);
        check(dst_o == 4'd12 && dst_vld_o, "R2 one cycle latency", dst_o, 12);
        @(negedge clk);
        check(!dst_vld_o, "R3 valid drops when idle", dst_vld_o, 0);
        check(dst_o == 4'd12, "R3 destination held", dst_o, 12);
        mode_i = 2'b11; hot_i = 4'd9; src_i = 4'd1;
        @(negedge clk);
        check(dst_o == 4'd12 && !dst_vld_o, "R3 inputs ignored without request", dst_o, 12);

        // Directed permutation corners
        check_perm(4'b0110, 2'b01, '0);
        check_perm(4'b1001, 2'b01, '0);
        check_perm(4'b0001, 2'b01, '0);
        check_perm(4'b0101, 2'b10, '0);
        check_perm(4'b0000, 2'b10, '0);
        check_perm(4'b1110, 2'b10, '0);
        check_perm(4'd7, 2'b11, 4'd7);
        check_perm(4'd2, 2'b11, 4'd7);
        check_perm(4'd15, 2'b11, 4'd0);

        // Exhaustive permutation sweep
        for (int s = 0; s < N; s++) begin
            check_perm(AW'(s), 2'b01, '0);
            check_perm(AW'(s), 2'b10, '0);
        end

        // R2/R4: back-to-back random stream, mixed modes
        @(negedge clk);
        req_i = 1'b1;
        src_i = AW'($urandom); mode_i = 2'($urandom); hot_i = AW'($urandom);
        for (int k = 0; k < 2000; k++) begin
            logic [AW-1:0] ps, ph, e;
            logic [1:0] pm;
            ps = src_i; pm = mode_i; ph = hot_i;
            @(negedge clk);
            case (pm)
                2'b00: begin
                    check(dst_o != ps && dst_vld_o, "R4 uniform avoids source", dst_o, ps);
                end
                2'b01: begin
                    e = ref_rev(ps);
                    check(dst_o == e && dst_vld_o == (e != ps), "R2 R6 stream bit reversal", dst_o, e);
                end
                2'b10: begin
                    e = ref_trn(ps);
                    check(dst_o == e && dst_vld_o == (e != ps), "R2 R7 stream transpose", dst_o, e);
                end
                default: begin
                    check(dst_o == ph && dst_vld_o == (ph != ps), "R2 R8 stream hot spot", dst_o, ph);
                end
            endcase
            src_i = AW'($urandom); mode_i = 2'($urandom); hot_i = AW'($urandom);
        end
        req_i = 1'b0;

        // R5: distribution for a fixed source
        for (int i = 0; i < N; i++) hist[i] = 0;
        mode_i = 2'b00; src_i = 4'd5; req_i = 1'b1;
        last = '0;
        for (int k = 0; k < 1600; k++) begin
            @(negedge clk);
            hist[dst_o]++;
            last = dst_o;
        end
        req_i = 1'b0;
        @(negedge clk);
        check(!dst_vld_o && dst_o == last, "R3 hold after stream", dst_o, last);
        check(hist[5] == 0, "R5 source never drawn", hist[5], 0);
        for (int i = 0; i < N; i++) begin
            if (i != 5) check(hist[i] >= 35 && hist[i] <= 200, "R5 node share", hist[i], 106);
        end

        summary();
        $finish;
    end

endmodule